// File: doc/BRIEF.md
# Shadow-Buffered Single-Channel PWM Generator

This block turns a free-running timer into a one-channel pulse-width modulator. A counter climbs from zero to the value held in the active period register, then restarts. The output level comes from comparing the counter with the active compare register. The compare value sets either the high time or the low time of each period, depending on a polarity bit in the control register.

Software can retune a running waveform without glitches by writing the next period and compare values into a shadow pair. The block copies the shadow pair into the active pair only at the moment the counter restarts, so the period in progress always completes with the values it started with. Writing the active registers directly takes effect on the next clock, which suits setup while the output is idle. The control register also stores a run bit, a mode bit that connects the comparator to the pin, and a two-bit sync-select field. This block has no sync input, so the sync-select field is only stored and read back.

Top module: `shadow_pwm`

## Requirements
- R1: Synchronous reset clears all five registers and the counter to zero. After reset every register reads 0 and `pwm_out` is 0.
- R2: Each register sits at a fixed byte offset: 0x08 active period, 0x0C active compare, 0x10 shadow period, 0x14 shadow compare, 0x2A control. Value registers are 32 bits. Control is 16 bits and keeps `wr_data[15:0]`. A read returns the register's current contents, zero-extended. Any other offset reads 0, and a write to it changes nothing.
- R3: Control bit 4 runs the counter. While the bit is set, the counter advances by one per clock and returns to 0 on the clock after it reaches or passes the active period P, so a period lasts P+1 clocks. While the bit is clear, the counter holds its value.
- R4: With control bit 9 set and bit 10 clear, `pwm_out` is high while the counter is below the active compare C and low otherwise. C=0 gives an output that never goes high.
- R5: When C is greater than or equal to P, the comparator output is high for the whole period. This includes the minimum setting P=1, C=1.
- R6: With control bit 10 set, the output is the inverse of the R4/R5 level, so C sets the low time.
- R7: With control bit 9 clear, `pwm_out` is 0 whatever the polarity, counter or compare values.
- R8: A write to the shadow period or shadow compare register marks the shadow pair pending. On the clock where the counter restarts, a pending shadow pair is copied into both active registers and the pending mark clears. The period in progress is unaffected.
- R9: A write to an active register takes effect on the next clock, whether or not the counter is running. When it lands on the same clock as a shadow copy, the direct write wins for that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| pwm_out | output | 1 | PWM waveform |

## Verification
Every register, including the counter, updates on the rising edge, and `pwm_out` and `rd_data` are purely combinational from that state. A write driven before edge E is therefore visible at the first falling edge after E. A shadow update first appears at the falling edge that follows the restart edge, where the counter reads 0. The bench drives its inputs at a falling edge and samples `pwm_out` at each later falling edge. It holds one expected level per sample index, counted from the falling edge where the counter first reads 0. For a period of P+1 clocks with mid-period writes, it indexes each expected level by that offset. Reads settle 1 ns after `rd_addr` changes at a falling edge.

// File: rtl/shpwm_pkg.sv
package shpwm_pkg;

    localparam int OFS_W  = 6;
    localparam int CTRL_W = 16;

    localparam logic [OFS_W-1:0] OFS_PER_ACT = 6'h08;
    localparam logic [OFS_W-1:0] OFS_CMP_ACT = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_PER_SH  = 6'h10;
    localparam logic [OFS_W-1:0] OFS_CMP_SH  = 6'h14;
    localparam logic [OFS_W-1:0] OFS_CTRL    = 6'h2A;

    localparam int BIT_RUN  = 4;
    localparam int BIT_MODE = 9;
    localparam int BIT_INV  = 10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PER_ACT,
        SEL_CMP_ACT,
        SEL_PER_SH,
        SEL_CMP_SH,
        SEL_CTRL
    } reg_sel_t;

    typedef struct packed {
        logic inv;
        logic mode;
        logic run;
    } ctrl_view_t;

    function automatic reg_sel_t decode_ofs(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_PER_ACT: return SEL_PER_ACT;
            OFS_CMP_ACT: return SEL_CMP_ACT;
            OFS_PER_SH:  return SEL_PER_SH;
            OFS_CMP_SH:  return SEL_CMP_SH;
            OFS_CTRL:    return SEL_CTRL;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_view_t decode_ctrl(input logic [CTRL_W-1:0] c);
        ctrl_view_t v;
        v.inv  = c[BIT_INV];
        v.mode = c[BIT_MODE];
        v.run  = c[BIT_RUN];
        return v;
    endfunction

endpackage

// File: rtl/shpwm_regs.sv
module shpwm_regs
    import shpwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [OFS_W-1:0]     wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic [OFS_W-1:0]     rd_addr,
    input  logic                 wrap,
    output logic [CNT_W-1:0]     rd_data,
    output logic [CNT_W-1:0]     per_act,
    output logic [CNT_W-1:0]     cmp_act,
    output ctrl_view_t           ctrl_v
);

    localparam int PAD_W = CNT_W - CTRL_W;

    logic [CNT_W-1:0]  per_sh, cmp_sh;
    logic [CTRL_W-1:0] ctrl_q;
    logic              pending;
    reg_sel_t          wsel, rsel;
    logic              wr_per_act, wr_cmp_act, wr_shadow;

    always_comb begin
        wsel       = decode_ofs(wr_addr);
        rsel       = decode_ofs(rd_addr);
        wr_per_act = wr_en && (wsel == SEL_PER_ACT);
        wr_cmp_act = wr_en && (wsel == SEL_CMP_ACT);
        wr_shadow  = wr_en && ((wsel == SEL_PER_SH) || (wsel == SEL_CMP_SH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_act <= '0;
            cmp_act <= '0;
            per_sh  <= '0;
            cmp_sh  <= '0;
            ctrl_q  <= '0;
            pending <= 1'b0;
        end else begin
            pending <= (pending && !wrap) || wr_shadow;
            if (wr_en && wsel == SEL_PER_SH) per_sh <= wr_data;
            if (wr_en && wsel == SEL_CMP_SH) cmp_sh <= wr_data;
            if (wr_en && wsel == SEL_CTRL)   ctrl_q <= wr_data[CTRL_W-1:0];
            if (wr_per_act)                  per_act <= wr_data;
            else if (wrap && pending)        per_act <= per_sh;
            if (wr_cmp_act)                  cmp_act <= wr_data;
            else if (wrap && pending)        cmp_act <= cmp_sh;
        end
    end

    always_comb begin
        case (rsel)
            SEL_PER_ACT: rd_data = per_act;
            SEL_CMP_ACT: rd_data = cmp_act;
            SEL_PER_SH:  rd_data = per_sh;
            SEL_CMP_SH:  rd_data = cmp_sh;
            SEL_CTRL:    rd_data = {{PAD_W{1'b0}}, ctrl_q};
            default:     rd_data = '0;
        endcase
    end

    assign ctrl_v = decode_ctrl(ctrl_q);

    // R8: a pending shadow pair lands in the active pair at the restart
    assert_shadow_load_R8: assert property (@(posedge clk) disable iff (rst)
        (wrap && pending && !wr_per_act) |=> per_act == $past(per_sh));

    // R8: away from a restart the active period changes only by a direct write
    assert_no_midperiod_load_R8: assert property (@(posedge clk) disable iff (rst)
        (!wrap && !wr_per_act) |=> $stable(per_act));

    // R9: a direct write to the active compare wins on the next clock
    assert_direct_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr_cmp_act |=> cmp_act == $past(wr_data));

endmodule

// File: rtl/shpwm_timer.sv
module shpwm_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    assign wrap = run && (cnt >= per);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (wrap) cnt <= '0;
        else if (run)  cnt <= cnt + 1'b1;
    end

    // R1: reset leaves the counter at zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> cnt == '0);

    // R3: a stopped counter keeps its value
    assert_stop_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt));

    // R3: the counter restarts from zero after reaching the period
    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt == '0);

endmodule

// File: rtl/shpwm_wave.sv
module shpwm_wave #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] cmp,
    input  logic             mode,
    input  logic             inv,
    output logic             pwm
);

    logic full_duty, level;

    always_comb begin
        full_duty = (cmp >= per);
        level     = full_duty || (cnt < cmp);
        pwm       = mode && (level ^ inv);
    end

endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
    import shpwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [5:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [5:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             pwm_out
);

    logic [CNT_W-1:0] per_act, cmp_act, cnt;
    logic             wrap;
    ctrl_view_t       ctrl_v;

    shpwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .wrap    (wrap),
        .rd_data (rd_data),
        .per_act (per_act),
        .cmp_act (cmp_act),
        .ctrl_v  (ctrl_v)
    );

    shpwm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_v.run),
        .per  (per_act),
        .cnt  (cnt),
        .wrap (wrap)
    );

    shpwm_wave #(.CNT_W(CNT_W)) u_wave (
        .cnt  (cnt),
        .per  (per_act),
        .cmp  (cmp_act),
        .mode (ctrl_v.mode),
        .inv  (ctrl_v.inv),
        .pwm  (pwm_out)
    );

    // R7: mode bit clear keeps the pin low
    assert_mode_off_low_R7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_v.mode |-> !pwm_out);

    // R5: compare at or above period gives a constant high in normal polarity
    assert_full_duty_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_v.mode && !ctrl_v.inv && cmp_act >= per_act) |-> pwm_out);

endmodule

// File: tb/shadow_pwm_bench.sv
module shadow_pwm_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    localparam logic [5:0] A_PA = 6'h08, A_CA = 6'h0C, A_PS = 6'h10,
                           A_CS = 6'h14, A_CT = 6'h2A;
    // control: bit4 run, bits7:6 sync select, bit9 mode, bit10 polarity
    localparam logic [31:0] C_NORM = 32'h02D0, C_INV = 32'h06D0,
                            C_NOMODE_INV = 32'h04D0, C_HALT = 32'h02C0;

    always #5 clk = ~clk;

    shadow_pwm u_shadow_pwm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    // expected pin level for scenario id at sample k (k=0: counter reads 0)
    function automatic logic exp_bit(input int id, input int k);
        case (id)
            0: return (k % 10) < 3;
            1: return !((k % 10) < 3);
            2, 3: return 1'b1;
            4, 5: return 1'b0;
            6: return (k < 10) ? (k < 3) : (((k - 10) % 6) < 2);
            7: return (k <= 5) ? ((k % 10) < 3) : ((k % 10) < 7);
            8: return (k < 10) ? (k < 3) : (((k - 10) % 10) < 1);
            9: return k < 13;
            10: return (k % 4) < 1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input int id);
        case (id)
            0: return "R4 normal polarity";
            1: return "R6 inverted polarity";
            2: return "R5 compare equals period";
            3: return "R5 minimum period";
            4: return "R4 zero compare";
            5: return "R7 mode clear";
            6: return "R8 shadow update";
            7: return "R9 direct active write";
            8: return "R9 direct write beats shadow copy";
            9: return "R3 counter halt";
            default: return "R3 period length";
        endcase
    endfunction

    // scheduled mid-run writes, driven after sample k
    task automatic drive_sched(input int id, input int k);
        wr_en = 1'b0;
        if (id == 6 && k == 3) begin wr_en = 1'b1; wr_addr = A_PS; wr_data = 32'd5; end
        if (id == 6 && k == 4) begin wr_en = 1'b1; wr_addr = A_CS; wr_data = 32'd2; end
        if (id == 7 && k == 5) begin wr_en = 1'b1; wr_addr = A_CA; wr_data = 32'd7; end
        if (id == 8 && k == 1) begin wr_en = 1'b1; wr_addr = A_PS; wr_data = 32'd9; end
        if (id == 8 && k == 2) begin wr_en = 1'b1; wr_addr = A_CS; wr_data = 32'd8; end
        if (id == 8 && k == 9) begin wr_en = 1'b1; wr_addr = A_CA; wr_data = 32'd1; end
        if (id == 9 && k == 1) begin wr_en = 1'b1; wr_addr = A_CT; wr_data = C_HALT; end
        if (id == 9 && k == 12) begin wr_en = 1'b1; wr_addr = A_CA; wr_data = 32'd2; end
    endtask

    task automatic scenario(input int id, input logic [31:0] p, input logic [31:0] c,
                            input logic [31:0] ctl, input int n);
        do_reset();
        wr(A_PA, p);
        wr(A_CA, c);
        wr(A_CT, ctl);
        for (int k = 0; k < n; k++) begin
            check(req_of(id), {31'd0, pwm_out}, {31'd0, exp_bit(id, k)});
            drive_sched(id, k);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 pin after reset", {31'd0, pwm_out}, 32'd0);
        rd_check("R1 active period", A_PA, 32'd0);
        rd_check("R1 active compare", A_CA, 32'd0);
        rd_check("R1 shadow period", A_PS, 32'd0);
        rd_check("R1 shadow compare", A_CS, 32'd0);
        rd_check("R1 control", A_CT, 32'd0);
    endtask

    task automatic test_readback();
        do_reset();
        wr(A_PA, 32'hDEAD_0011);
        wr(A_CA, 32'h0000_0007);
        wr(A_PS, 32'h1234_5678);
        wr(A_CS, 32'h8765_4321);
        wr(A_CT, 32'h000A_4C00);
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h2C, 32'hFFFF_FFFF);
        rd_check("R2 active period", A_PA, 32'hDEAD_0011);
        rd_check("R2 active compare", A_CA, 32'h0000_0007);
        rd_check("R2 shadow period", A_PS, 32'h1234_5678);
        rd_check("R2 shadow compare", A_CS, 32'h8765_4321);
        rd_check("R2 control truncated", A_CT, 32'h0000_4C00);
        rd_check("R2 unmapped read", 6'h04, 32'd0);
        rd_check("R2 unmapped read", 6'h00, 32'd0);
    endtask

    initial begin
        test_reset();
        test_readback();
        scenario(0, 32'd9, 32'd3, C_NORM, 30);
        scenario(1, 32'd9, 32'd3, C_INV, 20);
        scenario(2, 32'd4, 32'd4, C_NORM, 12);
        scenario(3, 32'd1, 32'd1, C_NORM, 6);
        scenario(4, 32'd5, 32'd0, C_NORM, 12);
        scenario(5, 32'd9, 32'd3, C_NOMODE_INV, 12);
        scenario(6, 32'd9, 32'd3, C_NORM, 34);
        scenario(7, 32'd9, 32'd3, C_NORM, 20);
        scenario(8, 32'd9, 32'd3, C_NORM, 30);
        scenario(9, 32'd9, 32'd3, C_NORM, 20);
        scenario(10, 32'd3, 32'd1, C_NORM, 16);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule